// File: doc/BRIEF.md
# Microprogrammed Control Sequencer for a 16-bit Accumulator Machine

This block is the control half of a small accumulator computer. It holds a 64-word microcode store and a 6-bit microprogram counter (`upc`). In every clock cycle the word at `upc` drives the datapath controls: the operand selects, the ALU and shifter codes, the register write enable and its target, the MAR and MBR loads, and the memory read and write strobes. The datapath sends back two status bits, `flag_n` and `flag_z`. They are taken from the ALU result of the current microinstruction. The block uses them to choose the next microaddress.

Each machine word holds a 3-bit opcode in bits 15..13 and a 13-bit operand address in bits 12..0. The microcode first fetches a word in four steps. It then decodes the opcode by doubling the instruction register and testing the sign flag, one opcode bit per step, starting from the most significant bit. After that it runs one of six instructions: add, subtract, load, store, jump, and jump-if-accumulator-zero. The register file, the ALU, the shifter and main memory are outside the block.

Microcode steps (states), named by address: FETCH_ADDR 0, FETCH_READ 1, PC_INC 2, LATCH_IR 3, TEST_B1 4, TEST_B0 5, ADD_ADDR..ADD_DONE 6-9, SUB_ADDR..SUB_DONE 10-15, TEST_LS 16, LD_ADDR..LD_DONE 17-20, ST_ADDR..ST_DONE 21-24, TEST_HI1 25, TEST_HI0 26, JMP_PC 27, JMP_DONE 28, JZ_TEST 29, JZ_DONE 30.

Transitions:
- Each step falls through to the next address unless it branches.
- LATCH_IR goes to TEST_HI1 when N is set.
- TEST_B1 goes to TEST_LS when N is set.
- TEST_B0 goes to SUB_ADDR when N is set.
- TEST_LS goes to ST_ADDR when N is set.
- TEST_HI1 goes to FETCH_ADDR when N is set.
- TEST_HI0 goes to JZ_TEST when N is set.
- JZ_TEST goes to JMP_PC when Z is set.
- Every *_DONE step jumps unconditionally to FETCH_ADDR.
- Store words 31 to 63 are unused. Each of them jumps unconditionally to FETCH_ADDR.

Top module: `mseq_core`

## Requirements
- R1: While `rst_n` is low, `upc` is 0. The first step after reset drives `ld_mar`=1, `mem_rd`=1, `alu_op`=pass and `a_sel`=1 (the PC register), so that the machine starts by fetching.
- R2: A step whose condition field is "none" (00) is followed by the step at `upc`+1.
- R3: A step whose condition field is "negative" (01) goes to its successor address when `flag_n` is 1, and to `upc`+1 otherwise.
- R4: A step whose condition field is "zero" (10) goes to its successor address when `flag_z` is 1, and to `upc`+1 otherwise.
- R5: A step whose condition field is "always" (11) goes to its successor address, whatever the flags are.
- R6: Datapath control encodings:
  - `alu_op`: 00 add, 01 and, 10 pass left, 11 ones' complement of left.
  - `shift_op`: 00 none, 01 left, 10 right.
  - Register numbers: 0 ACC, 1 PC, 2 IR, 3 TMP, 4 address mask (0x1FFF), 5 constant one.
  - The left operand is MBR when `src_mbr`=1.
  - The flags come from the ALU output before the shifter.
- R7: Fetch copies PC into MAR with a read, holds the read for a second cycle, adds one to PC, then loads MBR into IR. Non-jump instructions therefore leave PC one higher.
- R8: The opcode is decoded from the most significant bit down. Opcodes 110 and 111 return to FETCH_ADDR after 5 cycles and change neither ACC nor PC beyond the fetch.
- R9: ADD (000) sets ACC to ACC plus the memory word. LOAD (010) sets ACC to the memory word. Each takes 10 cycles.
- R10: SUB (001) adds one to ACC, then adds the ones' complement of the memory word. The result is ACC minus the word, and the instruction takes 12 cycles.
- R11: STORE (011) writes ACC to the memory word through MBR, with the write strobe held for two cycles. It takes 10 cycles.
- R12: JUMP (100) loads PC with IR AND the address mask, so the opcode bits are dropped. It takes 8 cycles.
- R13: JZER (101) passes ACC through the ALU. If ACC is zero it takes the JUMP steps (9 cycles). Otherwise PC is left alone (8 cycles).
- R14: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_n | input | 1 | Sign bit of the current ALU result |
| flag_z | input | 1 | Current ALU result is zero |
| upc | output | 6 | Microprogram counter |
| src_mbr | output | 1 | Left ALU operand from MBR (1) or register file (0) |
| alu_op | output | 2 | ALU function code |
| shift_op | output | 2 | Shifter code |
| ld_mbr | output | 1 | Load shifter result into MBR |
| ld_mar | output | 1 | Load shifter result into MAR |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| reg_we | output | 1 | Write shifter result to register file |
| dst_sel | output | 3 | Register written when `reg_we` is 1 |
| b_sel | output | 3 | Register on the right ALU operand |
| a_sel | output | 3 | Register on the left ALU operand |

## Verification
Two paths are the hardest to reach from the ports. The first is the taken JZER path, where step 29 branches backwards into the JUMP steps; it needs ACC to be exactly zero when the branch step runs. The second is a jump whose target address carries opcode bits that the mask must remove. The bench program builds both cases. A subtraction brings ACC to exactly zero before a JZER. A JUMP word has its full 13-bit address field set, so the mask has to strip the opcode bits, and the next instruction is found only because the 8-bit memory model folds the address. Both undefined opcodes, 110 and 111, are also executed. Together these reach every branch step in both directions.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int UA_W  = 6;
    localparam int SEL_W = 3;
    localparam int OPC_W = 2;

    typedef enum logic [1:0] {
        CND_NONE   = 2'b00,
        CND_NEG    = 2'b01,
        CND_ZERO   = 2'b10,
        CND_ALWAYS = 2'b11
    } cond_e;

    typedef enum logic [OPC_W-1:0] {
        ALU_ADD  = 2'b00,
        ALU_AND  = 2'b01,
        ALU_PASS = 2'b10,
        ALU_NOT  = 2'b11
    } alu_e;

    typedef enum logic [OPC_W-1:0] {
        SH_NONE  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_RSVD  = 2'b11
    } shift_e;

    typedef enum logic [SEL_W-1:0] {
        RG_ACC  = 3'd0,
        RG_PC   = 3'd1,
        RG_IR   = 3'd2,
        RG_TMP  = 3'd3,
        RG_MASK = 3'd4,
        RG_ONE  = 3'd5,
        RG_X6   = 3'd6,
        RG_X7   = 3'd7
    } reg_e;

    // Named microcode steps; the value is the control store address.
    typedef enum logic [UA_W-1:0] {
        U_FETCH_ADDR = 6'd0,
        U_FETCH_READ = 6'd1,
        U_PC_INC     = 6'd2,
        U_LATCH_IR   = 6'd3,
        U_TEST_B1    = 6'd4,
        U_TEST_B0    = 6'd5,
        U_ADD_ADDR   = 6'd6,
        U_ADD_READ   = 6'd7,
        U_ADD_SUM    = 6'd8,
        U_ADD_DONE   = 6'd9,
        U_SUB_ADDR   = 6'd10,
        U_SUB_READ   = 6'd11,
        U_SUB_INC    = 6'd12,
        U_SUB_COM    = 6'd13,
        U_SUB_SUM    = 6'd14,
        U_SUB_DONE   = 6'd15,
        U_TEST_LS    = 6'd16,
        U_LD_ADDR    = 6'd17,
        U_LD_READ    = 6'd18,
        U_LD_MOVE    = 6'd19,
        U_LD_DONE    = 6'd20,
        U_ST_ADDR    = 6'd21,
        U_ST_DATA    = 6'd22,
        U_ST_WRITE   = 6'd23,
        U_ST_DONE    = 6'd24,
        U_TEST_HI1   = 6'd25,
        U_TEST_HI0   = 6'd26,
        U_JMP_PC     = 6'd27,
        U_JMP_DONE   = 6'd28,
        U_JZ_TEST    = 6'd29,
        U_JZ_DONE    = 6'd30
    } step_e;

    // Microinstruction word; field order matches the bit layout, MSB first.
    typedef struct packed {
        logic              src_mbr;
        cond_e             cond;
        alu_e              alu;
        shift_e            sh;
        logic              ld_mbr;
        logic              ld_mar;
        logic              rd;
        logic              wr;
        logic              we;
        reg_e              dst;
        reg_e              bsel;
        reg_e              asel;
        logic [UA_W-1:0]   next;
    } uword_t;

    localparam int UWORD_W = $bits(uword_t);

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
    import mseq_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);

    localparam int DEPTH = 1 << AW;
    localparam logic [UA_W-1:0] HOME = UA_W'(U_FETCH_ADDR);

    // Unused store words: unconditional return to the fetch step.
    localparam uword_t FILL = '{
        src_mbr: 1'b0, cond: CND_ALWAYS, alu: ALU_PASS, sh: SH_NONE,
        ld_mbr: 1'b0, ld_mar: 1'b0, rd: 1'b0, wr: 1'b0, we: 1'b0,
        dst: RG_ACC, bsel: RG_ACC, asel: RG_ACC, next: HOME
    };

    logic [UA_W-1:0] a_ext;

    generate
        if (AW >= UA_W) begin : g_trunc
            assign a_ext = addr[UA_W-1:0];
        end else begin : g_pad
            assign a_ext = {{(UA_W-AW){1'b0}}, addr};
        end
    endgenerate

    always_comb begin
        word        = '0;
        word.cond   = CND_NONE;
        word.alu    = ALU_PASS;
        word.sh     = SH_NONE;
        word.dst    = RG_ACC;
        word.bsel   = RG_ACC;
        word.asel   = RG_ACC;
        word.next   = HOME;
        unique case (step_e'(a_ext))
            U_FETCH_ADDR: begin
                word.asel   = RG_PC;
                word.ld_mar = 1'b1;
                word.rd     = 1'b1;
            end
            U_FETCH_READ: begin
                word.rd     = 1'b1;
            end
            U_PC_INC: begin
                word.alu    = ALU_ADD;
                word.asel   = RG_PC;
                word.bsel   = RG_ONE;
                word.we     = 1'b1;
                word.dst    = RG_PC;
            end
            U_LATCH_IR: begin
                word.src_mbr = 1'b1;
                word.we      = 1'b1;
                word.dst     = RG_IR;
                word.cond    = CND_NEG;
                word.next    = UA_W'(U_TEST_HI1);
            end
            U_TEST_B1: begin
                word.alu    = ALU_ADD;
                word.sh     = SH_LEFT;
                word.asel   = RG_IR;
                word.bsel   = RG_IR;
                word.we     = 1'b1;
                word.dst    = RG_TMP;
                word.cond   = CND_NEG;
                word.next   = UA_W'(U_TEST_LS);
            end
            U_TEST_B0: begin
                word.asel   = RG_TMP;
                word.we     = 1'b1;
                word.dst    = RG_TMP;
                word.cond   = CND_NEG;
                word.next   = UA_W'(U_SUB_ADDR);
            end
            U_ADD_ADDR: begin
                word.asel   = RG_IR;
                word.ld_mar = 1'b1;
                word.rd     = 1'b1;
            end
            U_ADD_READ: begin
                word.rd     = 1'b1;
            end
            U_ADD_SUM: begin
                word.src_mbr = 1'b1;
                word.alu     = ALU_ADD;
                word.bsel    = RG_ACC;
                word.we      = 1'b1;
                word.dst     = RG_ACC;
            end
            U_ADD_DONE: begin
                word.cond   = CND_ALWAYS;
            end
            U_SUB_ADDR: begin
                word.asel   = RG_IR;
                word.ld_mar = 1'b1;
                word.rd     = 1'b1;
            end
            U_SUB_READ: begin
                word.rd     = 1'b1;
            end
            U_SUB_INC: begin
                word.alu    = ALU_ADD;
                word.asel   = RG_ACC;
                word.bsel   = RG_ONE;
                word.we     = 1'b1;
                word.dst    = RG_ACC;
            end
            U_SUB_COM: begin
                word.src_mbr = 1'b1;
                word.alu     = ALU_NOT;
                word.we      = 1'b1;
                word.dst     = RG_TMP;
            end
            U_SUB_SUM: begin
                word.alu    = ALU_ADD;
                word.asel   = RG_ACC;
                word.bsel   = RG_TMP;
                word.we     = 1'b1;
                word.dst    = RG_ACC;
            end
            U_SUB_DONE: begin
                word.cond   = CND_ALWAYS;
            end
            U_TEST_LS: begin
                word.asel   = RG_TMP;
                word.we     = 1'b1;
                word.dst    = RG_TMP;
                word.cond   = CND_NEG;
                word.next   = UA_W'(U_ST_ADDR);
            end
            U_LD_ADDR: begin
                word.asel   = RG_IR;
                word.ld_mar = 1'b1;
                word.rd     = 1'b1;
            end
            U_LD_READ: begin
                word.rd     = 1'b1;
            end
            U_LD_MOVE: begin
                word.src_mbr = 1'b1;
                word.we      = 1'b1;
                word.dst     = RG_ACC;
            end
            U_LD_DONE: begin
                word.cond   = CND_ALWAYS;
            end
            U_ST_ADDR: begin
                word.asel   = RG_IR;
                word.ld_mar = 1'b1;
            end
            U_ST_DATA: begin
                word.asel   = RG_ACC;
                word.ld_mbr = 1'b1;
                word.wr     = 1'b1;
            end
            U_ST_WRITE: begin
                word.wr     = 1'b1;
            end
            U_ST_DONE: begin
                word.cond   = CND_ALWAYS;
            end
            U_TEST_HI1: begin
                word.alu    = ALU_ADD;
                word.sh     = SH_LEFT;
                word.asel   = RG_IR;
                word.bsel   = RG_IR;
                word.we     = 1'b1;
                word.dst    = RG_TMP;
                word.cond   = CND_NEG;
                word.next   = HOME;
            end
            U_TEST_HI0: begin
                word.asel   = RG_TMP;
                word.we     = 1'b1;
                word.dst    = RG_TMP;
                word.cond   = CND_NEG;
                word.next   = UA_W'(U_JZ_TEST);
            end
            U_JMP_PC: begin
                word.alu    = ALU_AND;
                word.asel   = RG_IR;
                word.bsel   = RG_MASK;
                word.we     = 1'b1;
                word.dst    = RG_PC;
            end
            U_JMP_DONE: begin
                word.cond   = CND_ALWAYS;
            end
            U_JZ_TEST: begin
                word.asel   = RG_ACC;
                word.we     = 1'b1;
                word.dst    = RG_ACC;
                word.cond   = CND_ZERO;
                word.next   = UA_W'(U_JMP_PC);
            end
            U_JZ_DONE: begin
                word.cond   = CND_ALWAYS;
            end
            default: begin
                word = FILL;
            end
        endcase
    end

    initial begin
        if (DEPTH < 32) $error("control store too small for microcode");
    end

endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  logic [AW-1:0] cur,
    input  cond_e         cond,
    input  logic [AW-1:0] target,
    input  logic          flag_n,
    input  logic          flag_z,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0] seq;
    logic          taken;

    assign seq = cur + AW'(1);

    always_comb begin
        unique case (cond)
            CND_NONE:   taken = 1'b0;
            CND_NEG:    taken = flag_n;
            CND_ZERO:   taken = flag_z;
            CND_ALWAYS: taken = 1'b1;
            default:    taken = 1'b0;
        endcase
    end

    assign nxt = taken ? target : seq;

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flag_n,
    input  logic            flag_z,
    output logic [5:0]      upc,
    output logic            src_mbr,
    output logic [1:0]      alu_op,
    output logic [1:0]      shift_op,
    output logic            ld_mbr,
    output logic            ld_mar,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            reg_we,
    output logic [2:0]      dst_sel,
    output logic [2:0]      b_sel,
    output logic [2:0]      a_sel
);

    logic [UA_W-1:0] mpc;
    logic [UA_W-1:0] mpc_nxt;
    uword_t          uw;

    mseq_rom #(.AW(UA_W)) i_rom (
        .addr (mpc),
        .word (uw)
    );

    mseq_next #(.AW(UA_W)) i_next (
        .cur    (mpc),
        .cond   (uw.cond),
        .target (uw.next),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .nxt    (mpc_nxt)
    );

    // State register: the microprogram counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mpc <= UA_W'(U_FETCH_ADDR);
        end else begin
            mpc <= mpc_nxt;
        end
    end

    // Output process: datapath controls straight from the current word.
    always_comb begin
        upc      = mpc;
        src_mbr  = uw.src_mbr;
        alu_op   = uw.alu;
        shift_op = uw.sh;
        ld_mbr   = uw.ld_mbr;
        ld_mar   = uw.ld_mar;
        mem_rd   = uw.rd;
        mem_wr   = uw.wr;
        reg_we   = uw.we;
        dst_sel  = uw.dst;
        b_sel    = uw.bsel;
        a_sel    = uw.asel;
    end

    // R1: a cycle spent in reset leaves the counter at the fetch step.
    p_reset_home_r1: assert property (@(posedge clk)
        !rst_n |=> upc == 6'd0);

    // R2: sequential step advances by one.
    p_fall_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uw.cond == CND_NONE |=> mpc == $past(mpc) + UA_W'(1));

    // R3: negative-flag branch in both directions.
    p_neg_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.cond == CND_NEG && flag_n) |=> mpc == $past(uw.next));
    p_neg_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.cond == CND_NEG && !flag_n) |=> mpc == $past(mpc) + UA_W'(1));

    // R4: zero-flag branch in both directions.
    p_zero_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.cond == CND_ZERO && flag_z) |=> mpc == $past(uw.next));
    p_zero_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.cond == CND_ZERO && !flag_z) |=> mpc == $past(mpc) + UA_W'(1));

    // R5: unconditional jump.
    p_always_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uw.cond == CND_ALWAYS |=> mpc == $past(uw.next));

    // R14: read and write strobes never overlap.
    p_rd_wr_excl_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: the fetch step always addresses memory with a read.
    p_fetch_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mpc == UA_W'(U_FETCH_ADDR)) |-> (ld_mar && mem_rd) ##1 mem_rd);

endmodule

// File: tb/test_mseq_core.sv
module test_mseq_core;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 3000;
    localparam int N_INSTR    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_n, flag_z;
    logic [5:0]  upc;
    logic        src_mbr, ld_mbr, ld_mar, mem_rd, mem_wr, reg_we;
    logic [1:0]  alu_op, shift_op;
    logic [2:0]  dst_sel, b_sel, a_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    mseq_core i_mseq_core (
        .clk(clk), .rst_n(rst_n), .flag_n(flag_n), .flag_z(flag_z),
        .upc(upc), .src_mbr(src_mbr), .alu_op(alu_op), .shift_op(shift_op),
        .ld_mbr(ld_mbr), .ld_mar(ld_mar), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .reg_we(reg_we), .dst_sel(dst_sel), .b_sel(b_sel), .a_sel(a_sel)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Initial memory image: program and data.
    function automatic logic [15:0] init_word(input logic [7:0] a);
        case (a)
            8'h00: return 16'h4080;  // LOAD 80
            8'h01: return 16'h0081;  // ADD 81
            8'h02: return 16'h2082;  // SUB 82
            8'h03: return 16'h6090;  // STORE 90
            8'h04: return 16'hA020;  // JZER 20 (not taken)
            8'h05: return 16'h2083;  // SUB 83 -> zero
            8'h06: return 16'hA010;  // JZER 10 (taken)
            8'h10: return 16'hC000;  // opcode 110
            8'h11: return 16'hFFFF;  // opcode 111
            8'h12: return 16'h0084;  // ADD 84
            8'h13: return 16'h8030;  // JUMP 30
            8'h30: return 16'h4090;  // LOAD 90
            8'h31: return 16'h6091;  // STORE 91
            8'h32: return 16'h9ABC;  // JUMP 1ABC
            8'hBC: return 16'h4091;  // LOAD 91
            8'hBD: return 16'h2080;  // SUB 80
            8'h80: return 16'h0005;
            8'h81: return 16'h7FFF;
            8'h82: return 16'h0004;
            8'h83: return 16'h8000;
            8'h84: return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    // ---------------- datapath, ALU and memory model (R6 encodings) ----------
    logic [15:0] rf [8];
    logic [15:0] mem [256];
    logic [15:0] mbr;
    logic [12:0] mar;
    logic        rd_q, wr_q;
    logic [15:0] lhs, rhs, alu_y, sh_y;

    always_comb begin
        lhs = src_mbr ? mbr : rf[a_sel];
        rhs = rf[b_sel];
        case (alu_op)
            2'b00:   alu_y = lhs + rhs;
            2'b01:   alu_y = lhs & rhs;
            2'b10:   alu_y = lhs;
            default: alu_y = ~lhs;
        endcase
        flag_n = alu_y[15];
        flag_z = (alu_y == 16'h0000);
        case (shift_op)
            2'b01:   sh_y = alu_y << 1;
            2'b10:   sh_y = alu_y >> 1;
            default: sh_y = alu_y;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) rf[i] <= 16'h0000;
            rf[4] <= 16'h1FFF;
            rf[5] <= 16'h0001;
            mbr   <= 16'h0000;
            mar   <= 13'h0000;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
            for (int i = 0; i < 256; i++) mem[i] <= init_word(8'(i));
        end else begin
            if (reg_we) rf[dst_sel] <= sh_y;
            if (ld_mar) mar <= sh_y[12:0];
            if (ld_mbr) mbr <= sh_y;
            else if (mem_rd && rd_q) mbr <= mem[mar[7:0]];
            if (mem_wr && wr_q) mem[mar[7:0]] <= mbr;
            rd_q <= mem_rd;
            wr_q <= mem_wr;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] acc;
        logic [15:0] pc;
        int          cyc;
        bit          chk_mem;
        logic [7:0]  maddr;
        logic [15:0] mval;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Driver: runs an instruction-level model and queues expected results.
    task automatic predict();
        logic [15:0] rmem [256];
        logic [15:0] acc = 16'h0000;
        logic [15:0] pc  = 16'h0000;
        for (int i = 0; i < 256; i++) rmem[i] = init_word(8'(i));
        for (int k = 0; k < N_INSTR; k++) begin
            logic [15:0] ir;
            logic [12:0] ea;
            exp_t e;
            ir = rmem[pc[7:0]];
            pc = pc + 16'h0001;
            ea = ir[12:0];
            e.chk_mem = 1'b0;
            e.maddr   = ea[7:0];
            e.mval    = 16'h0000;
            case (ir[15:13])
                3'b000: begin acc = acc + rmem[ea[7:0]]; e.cyc = 10; e.tag = "R9 add"; end
                3'b001: begin acc = acc - rmem[ea[7:0]]; e.cyc = 12; e.tag = "R10 sub"; end
                3'b010: begin acc = rmem[ea[7:0]];       e.cyc = 10; e.tag = "R9 load"; end
                3'b011: begin
                    rmem[ea[7:0]] = acc; e.cyc = 10; e.tag = "R11 store";
                    e.chk_mem = 1'b1; e.mval = acc;
                end
                3'b100: begin pc = {3'b000, ea}; e.cyc = 8; e.tag = "R12 jump"; end
                3'b101: begin
                    if (acc == 16'h0000) begin pc = {3'b000, ea}; e.cyc = 9; end
                    else e.cyc = 8;
                    e.tag = "R13 jzer";
                end
                default: begin e.cyc = 5; e.tag = "R8 undefined"; end
            endcase
            e.acc = acc;
            e.pc  = pc;
            exp_q.push_back(e);
        end
    endtask

    initial begin
        predict();
        repeat (3) @(negedge clk);
        // R1: reset state and the fetch step's controls
        chk(upc == 6'd0, "R1", "upc in reset", longint'(upc), 0);
        chk(ld_mar && mem_rd, "R1", "fetch ld_mar&mem_rd", longint'({ld_mar, mem_rd}), 3);
        chk(alu_op == 2'b10 && a_sel == 3'd1, "R1", "fetch alu/a_sel",
            longint'({alu_op, a_sel}), longint'({2'b10, 3'd1}));
        chk(!mem_wr && !reg_we, "R1", "no write in reset", longint'({mem_wr, reg_we}), 0);
        rst_n = 1'b1;
    end

    // Monitor: at each return to the fetch step, compare with the queue.
    int  cyc = 0;
    int  wd = 0;
    int  overlap = 0;
    bit  started = 1'b0;

    always @(negedge clk) begin
        wd++;
        if (wd > WATCHDOG) begin
            chk(1'b0, "WATCHDOG", "run did not complete", wd, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rst_n) begin
            if (mem_rd && mem_wr) overlap++;
            if (upc == 6'd0) begin
                if (started) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rf[0] == e.acc, e.tag, "ACC", longint'(rf[0]), longint'(e.acc));
                    chk(rf[1] == e.pc, "R7", {e.tag, " PC"}, longint'(rf[1]), longint'(e.pc));
                    // cycle counts follow from the branch rules R2 R3 R4 R5 R6
                    chk(cyc == e.cyc, "R2 R3 R4 R5 R6", {e.tag, " cycles"},
                        longint'(cyc), longint'(e.cyc));
                    if (e.chk_mem)
                        chk(mem[e.maddr] == e.mval, "R11", "stored word",
                            longint'(mem[e.maddr]), longint'(e.mval));
                    if (exp_q.size() == 0) begin
                        chk(overlap == 0, "R14", "rd/wr overlap cycles", overlap, 0);
                        $display("CHECKS %0d ERRORS %0d", checks, errors);
                        $finish;
                    end
                end
                started = 1'b1;
                cyc = 1;
            end else begin
                cyc++;
            end
        end
    end

endmodule